// File: doc/BRIEF.md
# Timed-Access Register Write Guard

This block holds a small bank of 8-bit special-function registers and filters every write to them. Five of the registers are guarded: an ordinary write may only change a per-register subset of bits. To change the rest, software performs an unlock sequence. It writes 0xAA to a dedicated key register, which opens a window counted in retired instructions. It then writes 0x55 to the same key register. While the window is still open and the key register holds 0x55, a write to a guarded register is "timed" and may change every bit that the register allows to change at all. Some bits of some registers can never be written.

Four further registers are not guarded and take every written byte. One register clears its power-fail-warning bit when it is read. The CPU core that issues the strobes, and any hardware that sets status bits, sit outside this block. The block is fed the core's register write and read strobes, the register address, the write data and a one-cycle pulse for each retired instruction. It presents the register contents as a flat bus and returns a combinational read value for the addressed register.

Top module: `sfr_guard_top`

## Requirements
- R1: After reset the register at index 0 (memory control) holds cfg_mem_i AND 0xFB, index 1 (range control) holds cfg_part_i AND 0x01, index 2 (CRC control) holds cfg_crc_i AND 0xF0, and every other register, including the key register, holds 0x00.
- R2: The key register sits at address BASE_ADDR+9 (default 0xE9) and stores every byte written to it. A write of 0xAA to it while the window count is zero sets the window count to 6.
- R3: Each cycle with retire_i high lowers a nonzero window count by one. A zero count stays zero.
- R4: A write of 0xAA while the window count is nonzero does not reload the count. When a load of 6 and a retire pulse fall in the same cycle, the count becomes 6.
- R5: A write to a guarded register is timed only when the window count is nonzero and the key register already holds 0x55 before that write.
- R6: On a write to register k, a bit that is outside the writable mask of k keeps its value. A bit inside the writable mask takes the written value when it is inside the free mask of k or the write is timed. Otherwise it keeps its value.
- R7: Register k lives at address BASE_ADDR+k, default base 0xE0. The free and writable masks are: k=0 memory control 0x0F and 0xF7; k=1 range control 0xEF and 0xFE; k=2 CRC control 0xFF and 0x0F; k=3 power control 0xB9 and 0xFF; k=4 interrupt priority 0x7F and 0xFF.
- R8: Registers k=5 (CRC low), k=6 (CRC high), k=7 (random number) and k=8 (partition status) take every written byte, timed or not.
- R9: A read strobe to the power-control register (k=3) clears its bit 5 at the next edge, while rdata_o shows the value before the clear. A write in the same cycle takes precedence over the clear. A read of any other register changes nothing.
- R10: rdata_o returns the register at addr_i, or the key register, in the same cycle, and returns 0x00 for any other address.
- R11: regs_o carries register k on bits [8k+7:8k]. key_o carries the key register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mem_i | input | 8 | Boot configuration for memory control |
| cfg_part_i | input | 8 | Boot configuration for range control |
| cfg_crc_i | input | 8 | Boot configuration for CRC control |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| retire_i | input | 1 | One pulse per retired instruction |
| key_o | output | 8 | Key register contents |
| regs_o | output | 72 | All nine registers, register k on bits [8k+7:8k] |
| rdata_o | output | 8 | Read value for addr_i (combinational) |

## Verification
A write strobe held over one rising edge shows its result on regs_o and key_o right after that edge, so the scoreboard compares the queued expectation at the following falling edge. rdata_o is combinational and is compared at the falling edge inside the cycle in which the read strobe is driven. The read clear of the power-fail-warning bit is due one edge later, like a write. The window count has no port of its own. Its value is inferred from whether a guarded write that follows is treated as timed, so each window scenario (expiry, zero floor, no restart, load beating a retire) ends with a write whose timed and untimed results differ.

// File: rtl/sfr_guard_pkg.sv
package sfr_guard_pkg;

    localparam int NREG    = 9;
    localparam int KEY_IDX = 9;

    typedef logic [7:0] byte_t;

    localparam byte_t KEY_OPEN = 8'hAA;
    localparam byte_t KEY_ARM  = 8'h55;

    // per-register masks, indexed by address offset
    localparam byte_t FREE_TBL [NREG] = '{8'h0F, 8'hEF, 8'hFF, 8'hB9, 8'h7F,
                                          8'hFF, 8'hFF, 8'hFF, 8'hFF};
    localparam byte_t WRM_TBL  [NREG] = '{8'hF7, 8'hFE, 8'h0F, 8'hFF, 8'hFF,
                                          8'hFF, 8'hFF, 8'hFF, 8'hFF};
    localparam byte_t BOOT_TBL [NREG] = '{8'hFB, 8'h01, 8'hF0, 8'h00, 8'h00,
                                          8'h00, 8'h00, 8'h00, 8'h00};
    localparam byte_t RDCLR_TBL[NREG] = '{8'h00, 8'h00, 8'h00, 8'h20, 8'h00,
                                          8'h00, 8'h00, 8'h00, 8'h00};

    function automatic byte_t guard_merge(byte_t old_v, byte_t new_v,
                                          byte_t free_m, byte_t wr_m,
                                          logic timed);
        byte_t open_m;
        byte_t staged;
        open_m = timed ? 8'hFF : free_m;
        staged = (old_v & ~open_m) | (new_v & open_m);
        return (old_v & ~wr_m) | (staged & wr_m);
    endfunction

endpackage

// File: rtl/unlock_window.sv
module unlock_window
    import sfr_guard_pkg::*;
#(
    parameter int WIN_LOAD = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  key_wr,
    input  byte_t key_data,
    input  logic  retire,
    output byte_t key_o,
    output logic  timed_o
);
    localparam int CW = $clog2(WIN_LOAD + 1);
    localparam logic [CW-1:0] WIN_INIT = CW'(WIN_LOAD);

    typedef struct packed {
        byte_t         key;
        logic [CW-1:0] win;
    } win_st_t;

    win_st_t s_d, s_q;
    logic    load;

    always_comb begin
        s_d  = s_q;
        load = key_wr && (key_data == KEY_OPEN) && (s_q.win == '0);
        if (key_wr) begin
            s_d.key = key_data;
        end
        if (load) begin
            s_d.win = WIN_INIT;
        end else if (retire && (s_q.win != '0)) begin
            s_d.win = s_q.win - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign key_o   = s_q.key;
    assign timed_o = (s_q.win != '0) && (s_q.key == KEY_ARM);

    // R2: opening key on a closed window loads the full count
    a_r2_window_load: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data == KEY_OPEN && s_q.win == '0) |=> (s_q.win == WIN_INIT));

    // R3: an open window steps down once per retire pulse
    a_r3_window_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.win != '0 && retire) |=> (s_q.win == $past(s_q.win) - 1'b1));

    // R3: a closed window stays closed without the opening key
    a_r3_window_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.win == '0 && !(key_wr && key_data == KEY_OPEN)) |=> (s_q.win == '0));

    // R4: an open window is never reloaded
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.win != '0 && !retire) |=> $stable(s_q.win));

    // R2: key register follows writes
    a_r2_key_store: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (s_q.key == $past(key_data)));

endmodule

// File: rtl/guarded_reg.sv
module guarded_reg
    import sfr_guard_pkg::*;
#(
    parameter byte_t FREE_M = 8'hFF,
    parameter byte_t WR_M   = 8'hFF,
    parameter byte_t CLR_M  = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t rst_val,
    input  logic  wr,
    input  logic  rd,
    input  logic  timed,
    input  byte_t wdata,
    output byte_t q_o
);
    byte_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (rd) begin
            q_d = q_q & ~CLR_M;
        end
        if (wr) begin
            q_d = guard_merge(q_q, wdata, FREE_M, WR_M, timed);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= rst_val;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;

    // R9: no strobe, no change
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !rd) |=> (q_q == $past(q_q)));

    if (WR_M != 8'hFF) begin : g_locked
        // R6: bits outside the writable mask never move
        a_r6_locked_bits: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (((q_q ^ $past(q_q)) & ~WR_M) == 8'h00));
    end

    if (FREE_M != 8'hFF) begin : g_guarded
        // R6: an untimed write leaves guarded bits alone
        a_r6_untimed_guard: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !timed) |=> (((q_q ^ $past(q_q)) & ~FREE_M & ~CLR_M) == 8'h00));
    end

    if (CLR_M != 8'h00) begin : g_rdclr
        // R9: a read clears the warning bit
        a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && !wr) |=> ((q_q & CLR_M) == 8'h00));
    end

endmodule

// File: rtl/sfr_guard_top.sv
module sfr_guard_top
    import sfr_guard_pkg::*;
#(
    parameter byte_t BASE_ADDR = 8'hE0,
    parameter int    WIN_LOAD  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_mem_i,
    input  logic [7:0]        cfg_part_i,
    input  logic [7:0]        cfg_crc_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [7:0]        addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              retire_i,
    output logic [7:0]        key_o,
    output logic [NREG*8-1:0] regs_o,
    output logic [7:0]        rdata_o
);
    localparam byte_t KEY_ADDR = BASE_ADDR + byte_t'(KEY_IDX);

    byte_t cfg_arr [NREG];
    logic  key_wr;
    logic  timed;

    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            cfg_arr[k] = 8'h00;
        end
        cfg_arr[0] = cfg_mem_i;
        cfg_arr[1] = cfg_part_i;
        cfg_arr[2] = cfg_crc_i;
    end

    assign key_wr = wr_en_i && (addr_i == KEY_ADDR);

    unlock_window #(
        .WIN_LOAD (WIN_LOAD)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (wdata_i),
        .retire   (retire_i),
        .key_o    (key_o),
        .timed_o  (timed)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam byte_t MY_ADDR = BASE_ADDR + byte_t'(g);
        logic  hit;
        byte_t q_w;

        assign hit = (addr_i == MY_ADDR);

        guarded_reg #(
            .FREE_M (FREE_TBL[g]),
            .WR_M   (WRM_TBL[g]),
            .CLR_M  (RDCLR_TBL[g])
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val (cfg_arr[g] & BOOT_TBL[g]),
            .wr      (wr_en_i && hit),
            .rd      (rd_en_i && hit),
            .timed   (timed),
            .wdata   (wdata_i),
            .q_o     (q_w)
        );

        assign regs_o[g*8 +: 8] = q_w;
    end

    always_comb begin
        rdata_o = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (addr_i == BASE_ADDR + byte_t'(k)) begin
                rdata_o = regs_o[k*8 +: 8];
            end
        end
        if (addr_i == KEY_ADDR) begin
            rdata_o = key_o;
        end
    end

    // R5: a timed write needs the arming key in place beforehand
    a_r5_timed_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata_i != KEY_ARM) |=> !timed);

endmodule

// File: tb/sfr_guard_top_test.sv
module sfr_guard_top_test;

    localparam bit [7:0] BASE = 8'hE0;
    localparam bit [7:0] KEYA = 8'hE9;
    localparam bit [7:0] BFREE [9] = '{8'h0F, 8'hEF, 8'hFF, 8'hB9, 8'h7F,
                                       8'hFF, 8'hFF, 8'hFF, 8'hFF};
    localparam bit [7:0] BWR   [9] = '{8'hF7, 8'hFE, 8'h0F, 8'hFF, 8'hFF,
                                       8'hFF, 8'hFF, 8'hFF, 8'hFF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_mem = 8'hFF, cfg_part = 8'hFF, cfg_crc = 8'hFF;
    logic        wr_en = 1'b0, rd_en = 1'b0, retire = 1'b0;
    logic [7:0]  addr = 8'h00, wdata = 8'h00;
    logic [7:0]  key_o;
    logic [71:0] regs_o;
    logic [7:0]  rdata_o;

    always #5 clk = ~clk;

    sfr_guard_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mem_i  (cfg_mem),
        .cfg_part_i (cfg_part),
        .cfg_crc_i  (cfg_crc),
        .wr_en_i    (wr_en),
        .rd_en_i    (rd_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .retire_i   (retire),
        .key_o      (key_o),
        .regs_o     (regs_o),
        .rdata_o    (rdata_o)
    );

    typedef struct {
        bit       is_rd;
        int       idx;
        bit [7:0] exp;
        string    req;
    } item_t;

    item_t    sb[$];
    int       checks = 0;
    int       fails = 0;
    bit       done = 1'b0;
    bit [7:0] m [10];
    int       mwin = 0;

    // monitor: compare queued expectations away from the rising edge
    always @(negedge clk) begin
        item_t    it;
        bit [7:0] act;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            if (it.is_rd)          act = rdata_o;
            else if (it.idx == 9)  act = key_o;
            else                   act = regs_o[it.idx*8 +: 8];
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s idx=%0d actual=%02h expected=%02h",
                         it.req, it.idx, act, it.exp);
            end
        end
    end

    task automatic push(bit is_rd, int idx, bit [7:0] e, string req);
        item_t it;
        it.is_rd = is_rd; it.idx = idx; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    function automatic bit [7:0] bmerge(int i, bit [7:0] o, bit [7:0] d, bit t);
        bit [7:0] fr, mid;
        fr  = t ? 8'hFF : BFREE[i];
        mid = (o & ~fr) | (d & fr);
        return (o & ~BWR[i]) | (mid & BWR[i]);
    endfunction

    task automatic do_wr(bit [7:0] a, bit [7:0] d, bit ret, string req);
        int idx;
        bit t;
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d; retire = ret;
        t = (mwin != 0) && (m[9] == 8'h55);
        if (a == KEYA) begin
            idx = 9;
            m[9] = d;
            if (d == 8'hAA && mwin == 0) mwin = 6;
            else if (ret && mwin > 0) mwin--;
        end else begin
            idx = int'(a - BASE);
            m[idx] = bmerge(idx, m[idx], d, t);
            if (ret && mwin > 0) mwin--;
        end
        @(posedge clk); #1;
        wr_en = 1'b0; retire = 1'b0;
        push(1'b0, idx, m[idx], req);
    endtask

    task automatic do_ret(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; retire = 1'b1;
            if (mwin > 0) mwin--;
            @(posedge clk); #1; retire = 1'b0;
        end
    endtask

    task automatic do_rd(bit [7:0] a, string req);
        int idx;
        idx = int'(a) - int'(BASE);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = a;
        push(1'b1, idx, (idx >= 0 && idx <= 9) ? m[idx] : 8'h00, req);
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (idx == 3) m[3] = m[3] & ~8'h20;
        if (idx >= 0 && idx <= 9) push(1'b0, idx, m[idx], req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 10; i++) m[i] = 8'h00;
        m[0] = 8'hFB; m[1] = 8'h01; m[2] = 8'hF0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 10; i++) push(1'b0, i, m[i], "R1 reset");

        // R6 untimed guarded write, R8 plain registers
        do_wr(BASE + 8'd0, 8'h00, 1'b0, "R6 untimed memctl");
        do_wr(BASE + 8'd5, 8'h5A, 1'b0, "R8 crc low");
        do_wr(BASE + 8'd6, 8'hA5, 1'b0, "R8 crc high");
        do_wr(BASE + 8'd7, 8'h3C, 1'b0, "R8 random");
        do_wr(BASE + 8'd8, 8'hC3, 1'b0, "R8 partition status");
        // R7 free masks on untimed writes
        do_wr(BASE + 8'd2, 8'hFF, 1'b0, "R7 crcctl");
        do_wr(BASE + 8'd4, 8'hFF, 1'b0, "R7 intpri");
        do_wr(BASE + 8'd1, 8'hFF, 1'b0, "R7 rangectl");

        // R2 and R5: opening key alone does not arm
        do_wr(KEYA, 8'hAA, 1'b0, "R2 key store");
        do_wr(BASE + 8'd4, 8'h80, 1'b0, "R5 not armed");
        do_wr(KEYA, 8'h55, 1'b0, "R2 key arm");
        do_wr(BASE + 8'd4, 8'h80, 1'b0, "R5 timed intpri");
        do_wr(BASE + 8'd1, 8'h00, 1'b0, "R5 timed rangectl");
        do_wr(BASE + 8'd2, 8'h00, 1'b0, "R6 timed crcctl locked");

        // R3: window expires after six retires
        do_ret(6);
        do_wr(BASE + 8'd4, 8'h00, 1'b0, "R3 expired");

        // R4: no restart while open
        do_wr(KEYA, 8'hAA, 1'b0, "R4 open");
        do_wr(KEYA, 8'h55, 1'b0, "R4 arm");
        do_ret(5);
        do_wr(KEYA, 8'hAA, 1'b0, "R4 reopen attempt");
        do_wr(KEYA, 8'h55, 1'b0, "R4 rearm");
        do_wr(BASE + 8'd4, 8'h00, 1'b0, "R4 last open cycle");
        do_ret(1);
        do_wr(BASE + 8'd4, 8'h80, 1'b0, "R4 no restart");

        // R4: load beats a simultaneous retire
        do_wr(KEYA, 8'hAA, 1'b1, "R4 load with retire");
        do_wr(KEYA, 8'h55, 1'b0, "R4 arm");
        do_ret(5);
        do_wr(BASE + 8'd4, 8'h80, 1'b0, "R4 load wins");
        do_ret(1);

        // R3: zero floor
        do_ret(2);
        do_wr(KEYA, 8'h55, 1'b0, "R3 arm on closed");
        do_wr(BASE + 8'd4, 8'h00, 1'b0, "R3 floor");

        // R9 read clear of warning bit
        do_wr(BASE + 8'd3, 8'h20, 1'b0, "R7 pwrctl bit5");
        do_wr(BASE + 8'd3, 8'hFF, 1'b0, "R7 pwrctl untimed");
        do_rd(BASE + 8'd3, "R9 pwrctl read clear");
        do_rd(BASE + 8'd5, "R9 other read no effect");

        // R10 read mux, R11 layout through regs_o slices above
        do_rd(8'h10, "R10 unmapped");
        do_rd(KEYA, "R10 key read");
        do_rd(BASE + 8'd0, "R11 memctl read");

        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule